// File: doc/BRIEF.md
# Latency-Based Request Dispatcher

This block sits between a memory request stream and two downstream queues: one feeding a die-stacked DRAM cache and one feeding off-chip memory. Every request arrives with a dirty flag from a dirty-region tracker and a predicted-hit flag from a hit-miss predictor. The block picks one queue for each request and passes the request on through a one-entry output register.

Dirty requests always go to the cache, because only the cache holds their current data. Clean requests that are predicted to miss go to off-chip memory. Clean requests that are predicted to hit are steered by expected queuing delay. For each source, the delay is the pending-request count of the target bank multiplied by that source's typical unloaded latency. The bank of each source is taken from a configurable address bit-field. The request goes to the source with the smaller expected delay, and the cache wins ties. This balancing lets hit bursts use off-chip bandwidth that would otherwise sit idle.

Both typical latencies are run-time configuration inputs. Handshaking is valid/ready on the upstream side and on both queue sides.

Top module: `req_dispatch`

## Requirements
- R1: A request with req_dirty_i = 1 is sent to the cache queue, whatever the prediction flag, the counts and the latencies.
- R2: A clean request with req_hit_i = 0 is sent to the off-chip memory queue, whatever the counts and the latencies.
- R3: A clean request with req_hit_i = 1 is sent to off-chip memory when N_mem × L_mem is strictly less than N_cache × L_cache.
- R4: A clean request with req_hit_i = 1 is sent to the cache when N_mem × L_mem is greater than or equal to N_cache × L_cache. This includes equality and the case where both products are zero.
- R5: The N value for each source is the count of the bank given by its own address field. The cache bank is req_addr_i[8:6], and its count is cache_pend_i[b*6 +: 6]. The memory bank is req_addr_i[15:13], and its count is mem_pend_i[b*6 +: 6]. Each product is formed at full width (14 bits for 63 × 255), with no truncation.
- R6: disp_sel_o is one-hot while a request is held: bit 0 means the cache and bit 1 means memory. At most one of cache_valid_o and mem_valid_o is high at any time.
- R7: While the selected queue's ready is low, the held request keeps its address and its destination. It is never offered to the other queue, even if the counts change.
- R8: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. req_ready_o is high when the output register is empty or is being drained in that cycle, so back-to-back requests move at one per cycle. The accepted request appears at the outputs after that same edge.
- R9: After reset, cache_valid_o and mem_valid_o are low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Incoming request valid |
| req_ready_o | output | 1 | Incoming request accepted |
| req_addr_i | input | ADDR_W | Request address |
| req_dirty_i | input | 1 | Request touches a write-back (dirty) region |
| req_hit_i | input | 1 | Predictor expects a cache hit |
| cache_pend_i | input | C_NB*CNT_W | Per-bank pending counts, cache side |
| mem_pend_i | input | M_NB*CNT_W | Per-bank pending counts, off-chip side |
| cache_lat_i | input | LAT_W | Typical unloaded cache latency |
| mem_lat_i | input | LAT_W | Typical unloaded off-chip latency |
| cache_valid_o | output | 1 | Request offered to the cache queue |
| cache_ready_i | input | 1 | Cache queue can take a request |
| mem_valid_o | output | 1 | Request offered to the off-chip queue |
| mem_ready_i | input | 1 | Off-chip queue can take a request |
| disp_addr_o | output | ADDR_W | Address of the held request |
| disp_sel_o | output | 2 | One-hot destination of the held request |

## Verification
Routing is decided from the inputs present at the accepting edge, and the result shows up at the outputs one register later, directly after that edge. The bench therefore drives each request on a falling edge and lets the next rising edge accept it. It reads the destination and address on the falling edge that follows, and releases the request there. Stall checks are read on each falling edge while the chosen ready is held low, and counts are changed between those reads. After ready returns, the next request is expected on the falling edge after the draining edge.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    DST_NONE  = 2'b00,
    DST_CACHE = 2'b01,
    DST_MEM   = 2'b10
  } dst_e;
endpackage

// File: rtl/disp_bank_pick.sv
module disp_bank_pick #(
  parameter int BANK_W = 3,
  parameter int CNT_W  = 6,
  localparam int NB    = 1 << BANK_W
) (
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [NB*CNT_W-1:0] pend_i,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [CNT_W-1:0] cnt_arr [NB];

  for (genvar g = 0; g < NB; g++) begin : g_unpack
    assign cnt_arr[g] = pend_i[g*CNT_W +: CNT_W];
  end

  assign cnt_o = cnt_arr[bank_i];
endmodule

// File: rtl/disp_exp_lat.sv
module disp_exp_lat #(
  parameter int CNT_W  = 6,
  parameter int LAT_W  = 8,
  localparam int EXP_W = CNT_W + LAT_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [EXP_W-1:0] exp_o
);
  // widen both operands so the full product is kept
  assign exp_o = EXP_W'(cnt_i) * EXP_W'(lat_i);

  always_comb begin
    if (lat_i != '0) begin
      assert_no_overflow_R5: assert (exp_o >= EXP_W'(cnt_i));
    end
  end
endmodule

// File: rtl/disp_route.sv
module disp_route
  import disp_pkg::*;
#(
  parameter int EXP_W = 14
) (
  input  logic             dirty_i,
  input  logic             hit_i,
  input  logic [EXP_W-1:0] exp_cache_i,
  input  logic [EXP_W-1:0] exp_mem_i,
  output dst_e             dst_o
);
  always_comb begin
    if (dirty_i)                  dst_o = DST_CACHE;
    else if (!hit_i)              dst_o = DST_MEM;
    else if (exp_mem_i < exp_cache_i) dst_o = DST_MEM;
    else                          dst_o = DST_CACHE; // ties favour cache
  end

  always_comb begin
    assert_route_onehot_R6: assert ($onehot(dst_o));
  end
endmodule

// File: rtl/req_dispatch.sv
module req_dispatch
  import disp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 6,
  parameter int LAT_W      = 8,
  parameter int C_BANK_W   = 3,
  parameter int C_BANK_LSB = 6,
  parameter int M_BANK_W   = 3,
  parameter int M_BANK_LSB = 13,
  localparam int C_NB      = 1 << C_BANK_W,
  localparam int M_NB      = 1 << M_BANK_W,
  localparam int EXP_W     = CNT_W + LAT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic                   req_dirty_i,
  input  logic                   req_hit_i,
  input  logic [C_NB*CNT_W-1:0]  cache_pend_i,
  input  logic [M_NB*CNT_W-1:0]  mem_pend_i,
  input  logic [LAT_W-1:0]       cache_lat_i,
  input  logic [LAT_W-1:0]       mem_lat_i,
  output logic                   cache_valid_o,
  input  logic                   cache_ready_i,
  output logic                   mem_valid_o,
  input  logic                   mem_ready_i,
  output logic [ADDR_W-1:0]      disp_addr_o,
  output logic [1:0]             disp_sel_o
);
  logic [CNT_W-1:0] n_cache, n_mem;
  logic [EXP_W-1:0] e_cache, e_mem;
  dst_e             dst_d, dst_q;
  logic             out_valid_q;
  logic [ADDR_W-1:0] out_addr_q;
  logic             out_fire, in_fire;

  disp_bank_pick #(.BANK_W(C_BANK_W), .CNT_W(CNT_W)) u_pick_cache (
    .bank_i (req_addr_i[C_BANK_LSB +: C_BANK_W]),
    .pend_i (cache_pend_i),
    .cnt_o  (n_cache)
  );

  disp_bank_pick #(.BANK_W(M_BANK_W), .CNT_W(CNT_W)) u_pick_mem (
    .bank_i (req_addr_i[M_BANK_LSB +: M_BANK_W]),
    .pend_i (mem_pend_i),
    .cnt_o  (n_mem)
  );

  disp_exp_lat #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_exp_cache (
    .cnt_i (n_cache),
    .lat_i (cache_lat_i),
    .exp_o (e_cache)
  );

  disp_exp_lat #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_exp_mem (
    .cnt_i (n_mem),
    .lat_i (mem_lat_i),
    .exp_o (e_mem)
  );

  disp_route #(.EXP_W(EXP_W)) u_route (
    .dirty_i     (req_dirty_i),
    .hit_i       (req_hit_i),
    .exp_cache_i (e_cache),
    .exp_mem_i   (e_mem),
    .dst_o       (dst_d)
  );

  assign out_fire    = out_valid_q &&
                       (((dst_q == DST_CACHE) && cache_ready_i) ||
                        ((dst_q == DST_MEM)   && mem_ready_i));
  assign req_ready_o = !out_valid_q || out_fire;
  assign in_fire     = req_valid_i && req_ready_o;

  // decision is latched at acceptance and never re-evaluated while held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      dst_q       <= DST_NONE;
      out_addr_q  <= '0;
    end else if (in_fire) begin
      out_valid_q <= 1'b1;
      dst_q       <= dst_d;
      out_addr_q  <= req_addr_i;
    end else if (out_fire) begin
      out_valid_q <= 1'b0;
    end
  end

  assign cache_valid_o = out_valid_q && (dst_q == DST_CACHE);
  assign mem_valid_o   = out_valid_q && (dst_q == DST_MEM);
  assign disp_addr_o   = out_addr_q;
  assign disp_sel_o    = dst_q;

  assert_dirty_to_cache_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_dirty_i) |=> (cache_valid_o && !mem_valid_o));

  assert_miss_to_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_dirty_i && !req_hit_i) |=> (mem_valid_o && !cache_valid_o));

  assert_single_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cache_valid_o, mem_valid_o}));

  assert_sel_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_valid_o || mem_valid_o) |-> $onehot(disp_sel_o));

  assert_cache_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_valid_o && !cache_ready_i) |=> (cache_valid_o && $stable(disp_addr_o)));

  assert_mem_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(disp_addr_o)));

  assert_no_accept_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cache_valid_o && !cache_ready_i) || (mem_valid_o && !mem_ready_i)) |-> !req_ready_o);
endmodule

// File: tb/tb_req_dispatch.sv
module tb_req_dispatch;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 6;
  localparam int LAT_W  = 8;
  localparam int NB     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic                  req_valid, req_ready, req_dirty, req_hit;
  logic [ADDR_W-1:0]     req_addr;
  logic [NB*CNT_W-1:0]   c_pend, m_pend;
  logic [LAT_W-1:0]      c_lat, m_lat;
  logic                  c_valid, c_ready, m_valid, m_ready;
  logic [ADDR_W-1:0]     d_addr;
  logic [1:0]            d_sel;

  req_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_dirty_i(req_dirty), .req_hit_i(req_hit),
    .cache_pend_i(c_pend), .mem_pend_i(m_pend),
    .cache_lat_i(c_lat), .mem_lat_i(m_lat),
    .cache_valid_o(c_valid), .cache_ready_i(c_ready),
    .mem_valid_o(m_valid), .mem_ready_i(m_ready),
    .disp_addr_o(d_addr), .disp_sel_o(d_sel)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       dirty;
    logic       hit;
    logic [2:0] cb;
    logic [2:0] mb;
    logic [5:0] nc;
    logic [5:0] nm;
    logic [7:0] lc;
    logic [7:0] lm;
    logic       to_cache;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd1, 3'd2, 6'd9,  6'd0,  8'd50,  8'd10,  1'b1}, // R1 dirty, predicted miss
    '{1'b1, 1'b1, 3'd3, 3'd4, 6'd20, 6'd1,  8'd40,  8'd40,  1'b1}, // R1 dirty, mem cheaper
    '{1'b0, 1'b0, 3'd0, 3'd7, 6'd0,  6'd30, 8'd10,  8'd90,  1'b0}, // R2 miss, cache cheaper
    '{1'b0, 1'b0, 3'd6, 3'd1, 6'd0,  6'd0,  8'd0,   8'd0,   1'b0}, // R2 miss, all zero
    '{1'b0, 1'b1, 3'd5, 3'd2, 6'd4,  6'd3,  8'd10,  8'd13,  1'b0}, // R3 40 vs 39
    '{1'b0, 1'b1, 3'd2, 3'd5, 6'd4,  6'd5,  8'd10,  8'd8,   1'b1}, // R4 40 vs 40
    '{1'b0, 1'b1, 3'd7, 3'd0, 6'd4,  6'd41, 8'd10,  8'd1,   1'b1}, // R4 40 vs 41
    '{1'b0, 1'b1, 3'd4, 3'd3, 6'd0,  6'd0,  8'd30,  8'd60,  1'b1}, // R4 both zero
    '{1'b0, 1'b1, 3'd1, 3'd6, 6'd63, 6'd63, 8'd255, 8'd254, 1'b0}, // R5 R3 wide 16065 vs 16002
    '{1'b0, 1'b1, 3'd6, 3'd1, 6'd63, 6'd63, 8'd254, 8'd255, 1'b1}, // R5 R4 wide 16002 vs 16065
    '{1'b0, 1'b1, 3'd3, 3'd3, 6'd0,  6'd1,  8'd200, 8'd1,   1'b1}, // R4 0 vs 1
    '{1'b0, 1'b1, 3'd0, 3'd0, 6'd1,  6'd0,  8'd1,   8'd255, 1'b0}, // R3 1 vs 0
    '{1'b0, 1'b1, 3'd2, 3'd6, 6'd50, 6'd0,  8'd0,   8'd7,   1'b1}  // R4 zero latency tie
  };

  // non-target cache banks read 0, non-target memory banks read 63,
  // so a wrong bank pick skews the comparison
  task automatic set_req(input vec_t v);
    req_dirty = v.dirty;
    req_hit   = v.hit;
    req_addr  = (32'(v.cb) << 6) | (32'(v.mb) << 13) | 32'h4000_0000;
    c_lat     = v.lc;
    m_lat     = v.lm;
    for (int b = 0; b < NB; b++) begin
      c_pend[b*CNT_W +: CNT_W] = (b == int'(v.cb)) ? v.nc : 6'd0;
      m_pend[b*CNT_W +: CNT_W] = (b == int'(v.mb)) ? v.nm : 6'd63;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    req_valid = 0; req_dirty = 0; req_hit = 0; req_addr = '0;
    c_pend = '0; m_pend = '0; c_lat = '0; m_lat = '0;
    c_ready = 1; m_ready = 1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!c_valid && !m_valid, "R9 valids low in reset", {c_valid, m_valid}, 0);
    chk(req_ready, "R9 ready high in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!c_valid && !m_valid, "R9 valids low after reset", {c_valid, m_valid}, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      set_req(VECS[i]);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      chk((c_valid == VECS[i].to_cache) && (m_valid == !VECS[i].to_cache),
          $sformatf("R1-4 vector %0d route", i), {m_valid, c_valid},
          VECS[i].to_cache ? 1 : 2);
      chk(d_sel == (VECS[i].to_cache ? 2'b01 : 2'b10),
          $sformatf("R6 vector %0d sel", i), d_sel, VECS[i].to_cache ? 1 : 2);
      chk(d_addr == req_addr, $sformatf("R5 vector %0d addr", i), d_addr, req_addr);
      @(negedge clk);
    end

    // R7 cache stall, second request waits (R8)
    c_ready = 0;
    set_req(VECS[0]);
    req_valid = 1;
    @(negedge clk);
    req_addr = 32'h1234_5000;
    req_dirty = 0; req_hit = 0; // next one goes to memory
    for (int k = 0; k < 3; k++) begin
      c_pend = '1;
      chk(c_valid && !m_valid, "R7 cache hold valid", {m_valid, c_valid}, 1);
      chk(d_addr == ((32'd1 << 6) | (32'd2 << 13) | 32'h4000_0000), "R7 cache hold addr",
          d_addr, (32'd1 << 6) | (32'd2 << 13) | 32'h4000_0000);
      chk(!req_ready, "R8 no accept while held", req_ready, 0);
      @(negedge clk);
    end
    c_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(m_valid && !c_valid && d_addr == 32'h1234_5000, "R8 queued request follows drain",
        {m_valid, c_valid}, 2);
    @(negedge clk);

    // R7 memory stall, counts flip to favour the cache while held
    m_ready = 0;
    set_req(VECS[4]);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    m_pend = '1; m_lat = 8'd255; c_pend = '0;
    for (int k = 0; k < 3; k++) begin
      chk(m_valid && !c_valid, "R7 mem hold not rerouted", {m_valid, c_valid}, 2);
      @(negedge clk);
    end
    m_ready = 1;
    @(negedge clk);
    chk(!m_valid && !c_valid, "R8 drained after ready", {m_valid, c_valid}, 0);

    // R8 back-to-back throughput, one per cycle
    for (int k = 0; k < 4; k++) begin
      set_req(VECS[k]);
      req_addr = 32'h100 * (k + 1);
      req_valid = 1;
      chk(req_ready, "R8 ready during stream", req_ready, 1);
      @(negedge clk);
      chk(d_addr == 32'h100 * (k + 1) && (c_valid == VECS[k].to_cache) && (m_valid == !VECS[k].to_cache),
          "R8 stream output", d_addr, 32'h100 * (k + 1));
    end
    req_valid = 0;
    @(negedge clk);
    chk(!m_valid && !c_valid, "R8 stream empties", {m_valid, c_valid}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule